// File: doc/BRIEF.md
# Printer Port Data and Status Registers

This block holds the host-facing register logic of a legacy printer port. A simple bus with a one-bit offset, a read strobe, a write strobe and write data reaches two registers. Offset 0 is the data register, which holds an output latch. Offset 1 is a read-only status byte. The block drives the 8-bit printer data lines through an output enable and can also sample them.

Two modes are available. In the compatible mode the data lines are always driven, and reads of offset 0 return the latch. In the extended mode the data lines become bidirectional under a direction bit. When the direction bit is 0, the block drives the lines and reads return the latch. When it is 1, the drivers are released, reads return the line values, and writes change only the latch.

The status byte combines three kinds of bit. Some are live printer inputs, each passed through a two-flop synchronizer. One is an interrupt flag that latches on a rising acknowledge edge while the block is in extended mode. Another is a time-out flag that is meaningful only while an EPP mode is selected. Both flags are cleared by a status read, and the clear takes effect one cycle after the read.

Top module: `lpt_regs`

## Requirements
- R1: After reset the latch is 0x00, `pd_out` is 0x00, `pd_oe` is 1, and status bits 0, 1 and 2 read 1.
- R2: In compatible mode (`mode_ext`=0), a write to offset 0 loads `bus_wdata` into the latch, and `pd_out` shows it from the next cycle. `pd_oe` stays 1 whatever `dir_in` is, and a read of offset 0 returns the latch.
- R3: In extended mode with `dir_in`=0, `pd_oe` is 1 and a read of offset 0 returns the latch.
- R4: In extended mode with `dir_in`=1, `pd_oe` is 0 and a read of offset 0 returns `pd_in` in the same cycle. A write still loads the latch, and the latch appears on `pd_out`.
- R5: A write to offset 1 changes neither the latch nor any status bit.
- R6: Status bit 1 always reads 1.
- R7: Status bit 0 reads 1 while `epp_mode`=0. While `epp_mode`=1 it reads 0 until an `epp_timeout` pulse, and it reads 1 from the cycle after that pulse. A status read clears it from the following cycle, while the read cycle itself still returns 1. A time-out pulse in the same cycle as a read wins.
- R8: Status bit 2 reads 1 while `mode_ext`=0. In extended mode with `irq_en`=1, it drops to 0 when the synchronized `ack` rises (a 0-to-1 change). A status read sets it back to 1 from the following cycle. An edge in the same cycle as a read wins.
- R9: With `irq_en`=0, a rising `ack` leaves status bit 2 at 1.
- R10: Status bits 3 to 7 show the inputs err_n, slct, pe, ack and busy, in that bit order. Each passes through two flip-flops, so a change shows up after the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Register offset: 0 data, 1 status |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| mode_ext | input | 1 | 1 selects the extended bidirectional mode |
| dir_in | input | 1 | Direction bit: 1 releases the data lines in extended mode |
| irq_en | input | 1 | Interrupt enable for the acknowledge latch |
| epp_mode | input | 1 | Level: an EPP mode is selected |
| epp_timeout | input | 1 | Single-cycle EPP time-out event |
| pd_out | output | 8 | Value driven onto the data lines |
| pd_oe | output | 1 | Output enable for the data lines |
| pd_in | input | 8 | Sampled data line values |
| err_n | input | 1 | Printer error, 0 means error |
| slct | input | 1 | Printer selected and online |
| pe | input | 1 | Paper end |
| ack | input | 1 | Printer acknowledge |
| busy | input | 1 | Printer busy |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high together and that the bus stays idle during reset. They also assume that `epp_timeout` is high only while `epp_mode` is high. The stimulus drives every input shortly after the rising edge and raises each strobe for exactly one cycle, so these assumptions always hold. It keeps the printer inputs steady for several cycles around each edge it tests, so the two synchronizer stages never see a half-captured change.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    localparam int DATA_W   = 8;
    localparam int STAT_IN  = 5;
    localparam logic OFS_DATA = 1'b0;
    localparam logic OFS_STAT = 1'b1;

    // order of the synchronized printer inputs, also status bits 3..7
    localparam int SI_ERR  = 0;
    localparam int SI_SLCT = 1;
    localparam int SI_PE   = 2;
    localparam int SI_ACK  = 3;
    localparam int SI_BUSY = 4;

    typedef struct packed {
        logic [DATA_W-1:0] latch;
    } dp_state_t;

    typedef struct packed {
        logic to_flag;
        logic irq_n;
        logic ack_prev;
    } st_state_t;

endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            always_comb begin
                s1_d[i] = async_in[i];
                s2_d[i] = s1_q[i];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign sync_out = s2_q;

endmodule

// File: rtl/lpt_data_path.sv
module lpt_data_path
    import lpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mode_ext,
    input  logic              dir_in,
    input  logic [DATA_W-1:0] pd_in,
    output logic [DATA_W-1:0] pd_out,
    output logic              pd_oe,
    output logic [DATA_W-1:0] data_rd
);
    dp_state_t st_d, st_q;
    logic      listen;

    always_comb begin
        st_d   = st_q;
        if (wr_en)
            st_d.latch = wdata;
        // the direction bit only matters in extended mode
        listen = mode_ext & dir_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pd_out  = st_q.latch;
    assign pd_oe   = ~listen;
    assign data_rd = listen ? pd_in : st_q.latch;

    assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> pd_out == $past(wdata));

    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pd_out));

endmodule

// File: rtl/lpt_status.sv
module lpt_status
    import lpt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic               mode_ext,
    input  logic               irq_en,
    input  logic               epp_mode,
    input  logic               epp_timeout,
    input  logic [STAT_IN-1:0] pins,
    output logic [DATA_W-1:0]  status
);
    st_state_t st_d, st_q;
    logic      ack_rise;

    always_comb begin
        st_d          = st_q;
        ack_rise      = pins[SI_ACK] & ~st_q.ack_prev;
        st_d.ack_prev = pins[SI_ACK];

        // time-out flag: held at 0 outside EPP so entry starts clean
        if (!epp_mode)
            st_d.to_flag = 1'b0;
        else if (epp_timeout)
            st_d.to_flag = 1'b1;
        else if (rd_en)
            st_d.to_flag = 1'b0;

        // interrupt flag, active low
        if (!mode_ext)
            st_d.irq_n = 1'b1;
        else if (irq_en && ack_rise)
            st_d.irq_n = 1'b0;
        else if (rd_en)
            st_d.irq_n = 1'b1;

        status = {pins[SI_BUSY], pins[SI_ACK], pins[SI_PE], pins[SI_SLCT],
                  pins[SI_ERR],
                  (mode_ext ? st_q.irq_n : 1'b1),
                  1'b1,
                  (epp_mode ? st_q.to_flag : 1'b1)};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.to_flag  <= 1'b0;
            st_q.irq_n    <= 1'b1;
            st_q.ack_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_timeout_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (epp_mode && epp_timeout) |=> st_q.to_flag);

    assert_timeout_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !epp_timeout) |=> !st_q.to_flag);

    assert_irq_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !(irq_en && ack_rise)) |=> st_q.irq_n);

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && st_q.irq_n) |=> st_q.irq_n);

endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
    import lpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              mode_ext,
    input  logic              dir_in,
    input  logic              irq_en,
    input  logic              epp_mode,
    input  logic              epp_timeout,
    output logic [DATA_W-1:0] pd_out,
    output logic              pd_oe,
    input  logic [DATA_W-1:0] pd_in,
    input  logic              err_n,
    input  logic              slct,
    input  logic              pe,
    input  logic              ack,
    input  logic              busy
);
    logic               wr_data, rd_stat;
    logic [STAT_IN-1:0] raw_pins, sync_pins;
    logic [DATA_W-1:0]  data_rd, stat_rd;

    always_comb begin
        wr_data  = bus_wr & (bus_addr == OFS_DATA);
        rd_stat  = bus_rd & (bus_addr == OFS_STAT);
        raw_pins = '0;
        raw_pins[SI_ERR]  = err_n;
        raw_pins[SI_SLCT] = slct;
        raw_pins[SI_PE]   = pe;
        raw_pins[SI_ACK]  = ack;
        raw_pins[SI_BUSY] = busy;
        bus_rdata = (bus_addr == OFS_STAT) ? stat_rd : data_rd;
    end

    lpt_sync #(.W(STAT_IN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_pins),
        .sync_out (sync_pins)
    );

    lpt_data_path u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_data),
        .wdata    (bus_wdata),
        .mode_ext (mode_ext),
        .dir_in   (dir_in),
        .pd_in    (pd_in),
        .pd_out   (pd_out),
        .pd_oe    (pd_oe),
        .data_rd  (data_rd)
    );

    lpt_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_stat),
        .mode_ext    (mode_ext),
        .irq_en      (irq_en),
        .epp_mode    (epp_mode),
        .epp_timeout (epp_timeout),
        .pins        (sync_pins),
        .status      (stat_rd)
    );

    assert_status_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_STAT) |=> $stable(pd_out));

endmodule

// File: tb/tb_lpt_regs.sv
module tb_lpt_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00, bus_rdata;
    logic       mode_ext = 1'b0, dir_in = 1'b0, irq_en = 1'b0;
    logic       epp_mode = 1'b0, epp_timeout = 1'b0;
    logic [7:0] pd_out, pd_in = 8'h00;
    logic       pd_oe;
    logic       err_n = 1'b1, slct = 1'b1, pe = 1'b0, ack = 1'b1, busy = 1'b0;

    int n_run = 0, n_fail = 0, cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lpt_regs dut (.*);

    // behavioural reference
    bit [4:0] m_s1, m_s2;
    bit       m_ackprev, m_to, m_irqn;
    bit [7:0] m_latch;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_ackprev = 0;
            m_to = 0; m_irqn = 1; m_latch = 0;
        end else begin
            if (bus_wr && bus_addr == 1'b0) m_latch = bus_wdata;
            if (!epp_mode) m_to = 0;
            else if (epp_timeout) m_to = 1;
            else if (bus_rd && bus_addr) m_to = 0;
            if (!mode_ext) m_irqn = 1;
            else if (irq_en && m_s2[3] && !m_ackprev) m_irqn = 0;
            else if (bus_rd && bus_addr) m_irqn = 1;
            m_ackprev = m_s2[3];
            m_s2 = m_s1;
            m_s1 = {busy, ack, pe, slct, err_n};
        end
    end

    function automatic bit [7:0] exp_rdata();
        if (bus_addr)
            return {m_s2, (mode_ext ? m_irqn : 1'b1), 1'b1, (epp_mode ? m_to : 1'b1)};
        return (mode_ext && dir_in) ? pd_in : m_latch;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (rst_n && !done) begin
        chk("R2", pd_out, m_latch);
        chk("R3", {7'd0, pd_oe}, {7'd0, !(mode_ext && dir_in)});
        chk(bus_addr ? "R8" : "R4", bus_rdata, exp_rdata());
    end

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got hang expected finish");
            finish_up();
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic a, logic [7:0] d);
        bus_addr = a; bus_wr = 1; bus_wdata = d;
        tick();
        bus_wr = 0;
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        bus_addr = 1;
        @(negedge clk);
        chk("R1", pd_out, 8'h00);
        chk("R1", {7'd0, pd_oe}, 8'h01);
        chk("R1", bus_rdata & 8'h07, 8'h07);
        tick(3);
        @(negedge clk);
        chk("R10", bus_rdata, 8'h5F);
        chk("R6", {7'd0, bus_rdata[1]}, 8'h01);

        // compatible mode
        tick(); wr(0, 8'hA5);
        @(negedge clk); chk("R2", pd_out, 8'hA5);
        tick(); dir_in = 1; bus_addr = 0;
        @(negedge clk);
        chk("R2", {7'd0, pd_oe}, 8'h01);
        chk("R2", bus_rdata, 8'hA5);

        // write to status offset ignored
        tick(); wr(1, 8'h00);
        @(negedge clk);
        chk("R5", pd_out, 8'hA5);
        chk("R5", bus_rdata, 8'h5F);

        // extended, direction out
        tick(); mode_ext = 1; dir_in = 0; wr(0, 8'h3C);
        @(negedge clk);
        chk("R3", {7'd0, pd_oe}, 8'h01);
        chk("R3", bus_rdata, 8'h3C);

        // extended, direction in
        tick(); dir_in = 1; pd_in = 8'h96;
        @(negedge clk);
        chk("R4", {7'd0, pd_oe}, 8'h00);
        chk("R4", bus_rdata, 8'h96);
        tick(); wr(0, 8'h11);
        @(negedge clk);
        chk("R4", pd_out, 8'h11);
        chk("R4", bus_rdata, 8'h96);
        tick(); dir_in = 0;
        @(negedge clk); chk("R4", bus_rdata, 8'h11);

        // interrupt latch
        tick(); irq_en = 1; bus_addr = 1; ack = 0;
        tick(5); ack = 1;
        tick(5);
        @(negedge clk); chk("R8", {7'd0, bus_rdata[2]}, 8'h00);
        tick(); bus_rd = 1;
        @(negedge clk); chk("R8", {7'd0, bus_rdata[2]}, 8'h00);
        tick(); bus_rd = 0;
        @(negedge clk); chk("R8", {7'd0, bus_rdata[2]}, 8'h01);
        tick(); ack = 0; tick(5); ack = 1; tick(5); mode_ext = 0;
        @(negedge clk); chk("R8", {7'd0, bus_rdata[2]}, 8'h01);
        tick(); mode_ext = 1; bus_rd = 1; tick(); bus_rd = 0;

        // masked
        tick(); irq_en = 0; ack = 0; tick(5); ack = 1; tick(5);
        @(negedge clk); chk("R9", {7'd0, bus_rdata[2]}, 8'h01);

        // time-out flag
        tick(); epp_mode = 1;
        @(negedge clk); chk("R7", {7'd0, bus_rdata[0]}, 8'h00);
        tick(); epp_timeout = 1; tick(); epp_timeout = 0;
        @(negedge clk); chk("R7", {7'd0, bus_rdata[0]}, 8'h01);
        tick(); bus_rd = 1;
        @(negedge clk); chk("R7", {7'd0, bus_rdata[0]}, 8'h01);
        tick(); bus_rd = 0;
        @(negedge clk); chk("R7", {7'd0, bus_rdata[0]}, 8'h00);
        tick(); bus_rd = 1; epp_timeout = 1; tick(); bus_rd = 0; epp_timeout = 0;
        @(negedge clk); chk("R7", {7'd0, bus_rdata[0]}, 8'h01);
        tick(); epp_mode = 0;
        @(negedge clk); chk("R7", {7'd0, bus_rdata[0]}, 8'h01);

        // live inputs through the synchronizer
        tick(); err_n = 0; busy = 1; pe = 1; slct = 0;
        @(negedge clk); chk("R10", bus_rdata[7:3], 5'b01011);
        tick(2);
        @(negedge clk); chk("R10", bus_rdata[7:3], 5'b11100);
        chk("R6", {7'd0, bus_rdata[1]}, 8'h01);

        tick(4);
        finish_up();
    end
endmodule